// File: doc/BRIEF.md
# BCH8 Sector Bit-Error Corrector

This block applies the output of a BCH error-locator to one 512-byte sector held in an external buffer. The locator reports up to eight bit positions, counted from the tail of a codeword made of 104 parity bits followed by 4096 data bits. The block turns each position that lands in the data area into a byte address and a single-bit mask. It then performs a read-modify-write of that byte through a simple buffer port.

A run begins with a one-cycle `start`. At that moment the block captures the error count, the location list, the uncorrectable flag and the stored parity bytes from the spare area. If every stored parity byte is 0xFF, the sector is treated as freshly erased and nothing is touched. Otherwise, if the locator declared the sector uncorrectable, the block reports failure and leaves the buffer unchanged. In all other cases it walks the list one entry at a time. When the run ends, `done` pulses for one cycle and `status` and `flips` describe the result.

Top module: `sector_bitfix`

## Requirements
- R1: After reset, `done`, `buf_rd_en` and `buf_wr_en` are low, `status` is 2'b00 and `flips` is 0.
- R2: When all 13 captured parity bytes equal 0xFF, the run ends with `status` 2'b01 and `flips` 0, and the buffer is not written. This holds even when the uncorrectable flag is set.
- R3: When the parity bytes are not all 0xFF and the uncorrectable flag is set, the run ends with `status` 2'b11 and `flips` 0, and the buffer is not written.
- R4: A location of 103 or less is a parity bit and is skipped. A location of 4200 or more lies beyond the codeword and is also skipped.
- R5: For a location L from 104 to 4199, let a = L − 104. The byte at address (4095 − a) / 8 is XORed with the mask 1 << (a mod 8). Location 104 therefore hits byte 511 bit 0, and location 4199 hits byte 0 bit 7.
- R6: Each correction is a read cycle (`buf_rd_en` high) followed at once by a write cycle (`buf_wr_en` high) to the same address. `buf_rdata` is valid in the cycle after the read, and `buf_wdata` is that byte with exactly one bit inverted.
- R7: Only the first min(`err_count`, 8) entries of the list are used. Entry i sits at bits [13*i+12 : 13*i] of `err_locs`. A count above 8 is treated as 8.
- R8: A run that is neither erased nor uncorrectable ends with `status` 2'b10 if at least one bit was flipped, and 2'b00 otherwise. `flips` equals the number of entries applied, and a repeated location is applied again, which restores the bit.
- R9: `done` is high for exactly one cycle per run. `status` and `flips` hold their values after `done` until the next accepted `start`. A `start` that arrives while a run is in progress is ignored, and so are input changes during that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sector; accepted only when idle |
| err_count | input | 4 | Number of valid location entries |
| err_locs | input | 104 | Eight packed 13-bit error locations |
| uncorrectable | input | 1 | Locator reports too many errors |
| stored_ecc | input | 104 | Thirteen parity bytes read from the spare area |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_rd_en | output | 1 | Buffer read strobe |
| buf_rdata | input | 8 | Buffer read data, one cycle after the strobe |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Corrected byte |
| done | output | 1 | One-cycle end-of-sector pulse |
| status | output | 2 | 00 clean, 01 erased, 10 corrected, 11 uncorrectable |
| flips | output | 4 | Number of bits flipped in the last run |

## Verification
The bench builds the block with its default parameters: a 512-byte sector, 26 parity nibbles, 13 stored parity bytes and eight list entries. At this size every location value can be swept one run at a time. The sweep runs from 0 up past the end of the codeword, so both skip regions and every byte and bit position of the data area are hit. The 4-bit count field also reaches the values above eight, which exercises the clamp. Random multi-entry runs, duplicate locations, the erased and uncorrectable paths, and starts issued mid-run are compared against an arithmetic model of the address mirroring.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

  typedef enum logic [1:0] {
    FIX_CLEAN  = 2'b00,
    FIX_ERASED = 2'b01,
    FIX_OK     = 2'b10,
    FIX_FAIL   = 2'b11
  } fix_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_PICK,
    S_READ,
    S_WRITE,
    S_DONE
  } fix_state_e;

endpackage

// File: rtl/bfx_erase_detect.sv
module bfx_erase_detect #(
  parameter int ECC_BYTES = 13
) (
  input  logic [ECC_BYTES*8-1:0] ecc,
  output logic                   all_ones
);

  logic [ECC_BYTES-1:0] byte_ff;

  for (genvar g = 0; g < ECC_BYTES; g++) begin : g_byte
    assign byte_ff[g] = &ecc[g*8 +: 8];
  end

  assign all_ones = &byte_ff;

endmodule

// File: rtl/bfx_loc_map.sv
module bfx_loc_map #(
  parameter int SECTOR_BYTES = 512,
  parameter int ECC_NIBBLES  = 26,
  parameter int LOC_W        = 13,
  parameter int ADDR_W       = 9
) (
  input  logic [LOC_W-1:0]  loc,
  output logic              hit,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [7:0]        bit_mask
);

  localparam int ECC_BITS  = 4 * ECC_NIBBLES;
  localparam int DATA_BITS = 8 * SECTOR_BYTES;
  localparam int CW_BITS   = ECC_BITS + DATA_BITS;

  // location lies in the data part of the codeword
  function automatic logic in_data(input logic [LOC_W-1:0] l);
    return (int'(l) >= ECC_BITS) && (int'(l) < CW_BITS);
  endfunction

  // mirror the tail-relative position into a byte address
  function automatic logic [ADDR_W-1:0] to_byte(input logic [LOC_W-1:0] l);
    logic [31:0] adj;
    adj = 32'(l) - 32'(ECC_BITS);
    return ADDR_W'((32'(DATA_BITS - 1) - adj) >> 3);
  endfunction

  function automatic logic [7:0] to_mask(input logic [LOC_W-1:0] l);
    logic [31:0] adj;
    adj = 32'(l) - 32'(ECC_BITS);
    return 8'(1) << adj[2:0];
  endfunction

  assign hit       = in_data(loc);
  assign byte_addr = to_byte(loc);
  assign bit_mask  = to_mask(loc);

endmodule

// File: rtl/sector_bitfix.sv
module sector_bitfix
  import bfx_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int ECC_NIBBLES  = 26,
  parameter int ECC_BYTES    = 13,
  parameter int MAX_LOCS     = 8,
  parameter int LOC_W        = $clog2(4*ECC_NIBBLES + 8*SECTOR_BYTES),
  parameter int ADDR_W       = $clog2(SECTOR_BYTES),
  parameter int CNT_W        = $clog2(MAX_LOCS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [CNT_W-1:0]          err_count,
  input  logic [MAX_LOCS*LOC_W-1:0] err_locs,
  input  logic                      uncorrectable,
  input  logic [ECC_BYTES*8-1:0]    stored_ecc,
  output logic [ADDR_W-1:0]         buf_addr,
  output logic                      buf_rd_en,
  input  logic [7:0]                buf_rdata,
  output logic                      buf_wr_en,
  output logic [7:0]                buf_wdata,
  output logic                      done,
  output logic [1:0]                status,
  output logic [CNT_W-1:0]          flips
);

  fix_state_e               state_q;
  fix_status_e              status_q;
  logic [CNT_W-1:0]         idx_q, cnt_q, flips_q;
  logic [MAX_LOCS*LOC_W-1:0] locs_q;
  logic [ECC_BYTES*8-1:0]   ecc_q;
  logic                     unc_q;
  logic [ADDR_W-1:0]        addr_q;
  logic [7:0]               mask_q;

  logic [LOC_W-1:0]  cur_loc;
  logic              map_hit, erased;
  logic [ADDR_W-1:0] map_addr;
  logic [7:0]        map_mask;

  function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] n);
    return (int'(n) > MAX_LOCS) ? CNT_W'(MAX_LOCS) : n;
  endfunction

  always_comb begin
    cur_loc = '0;
    for (int i = 0; i < MAX_LOCS; i++)
      if (int'(idx_q) == i) cur_loc = locs_q[i*LOC_W +: LOC_W];
  end

  bfx_erase_detect #(.ECC_BYTES(ECC_BYTES)) u_erase (
    .ecc      (ecc_q),
    .all_ones (erased)
  );

  bfx_loc_map #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .ECC_NIBBLES  (ECC_NIBBLES),
    .LOC_W        (LOC_W),
    .ADDR_W       (ADDR_W)
  ) u_map (
    .loc       (cur_loc),
    .hit       (map_hit),
    .byte_addr (map_addr),
    .bit_mask  (map_mask)
  );

  // named internal events
  logic ev_start, ev_last, ev_apply, ev_skip, ev_fix;
  assign ev_start = start && (state_q == S_IDLE);
  assign ev_last  = (state_q == S_PICK) && (idx_q == cnt_q);
  assign ev_apply = (state_q == S_PICK) && !ev_last && map_hit;
  assign ev_skip  = (state_q == S_PICK) && !ev_last && !map_hit;
  assign ev_fix   = (state_q == S_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      status_q <= FIX_CLEAN;
      idx_q    <= '0;
      cnt_q    <= '0;
      flips_q  <= '0;
      locs_q   <= '0;
      ecc_q    <= '0;
      unc_q    <= 1'b0;
      addr_q   <= '0;
      mask_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (ev_start) begin
          cnt_q   <= clamp_count(err_count);
          locs_q  <= err_locs;
          ecc_q   <= stored_ecc;
          unc_q   <= uncorrectable;
          idx_q   <= '0;
          flips_q <= '0;
          state_q <= S_CHECK;
        end
        S_CHECK: begin
          if (erased) begin
            status_q <= FIX_ERASED;
            state_q  <= S_DONE;
          end else if (unc_q) begin
            status_q <= FIX_FAIL;
            state_q  <= S_DONE;
          end else begin
            state_q  <= S_PICK;
          end
        end
        S_PICK: begin
          if (ev_last) begin
            status_q <= (flips_q != '0) ? FIX_OK : FIX_CLEAN;
            state_q  <= S_DONE;
          end else if (ev_apply) begin
            addr_q  <= map_addr;
            mask_q  <= map_mask;
            state_q <= S_READ;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_READ:  state_q <= S_WRITE;
        S_WRITE: begin
          flips_q <= flips_q + 1'b1;
          idx_q   <= idx_q + 1'b1;
          state_q <= S_PICK;
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign buf_addr  = addr_q;
  assign buf_rd_en = (state_q == S_READ);
  assign buf_wr_en = ev_fix;
  assign buf_wdata = buf_rdata ^ mask_q;
  assign done      = (state_q == S_DONE);
  assign status    = status_q;
  assign flips     = flips_q;

  // R6: a write always follows a read of the same byte
  assert_wr_after_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> ($past(buf_rd_en) && ($past(buf_addr) == buf_addr)));

  // R6: a read is always followed by its write
  assert_rd_then_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |=> buf_wr_en);

  // R9: end pulse is a single cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: erased sector flips nothing
  assert_erased_no_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == FIX_ERASED) |-> (flips == '0));

  // R3: uncorrectable sector flips nothing
  assert_fail_no_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == FIX_FAIL) |-> (flips == '0));

  // R7: never more flips than list entries
  assert_flip_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(flips) <= MAX_LOCS));

  // R8: a corrected status implies at least one flip
  assert_ok_has_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == FIX_OK) |-> (flips != '0));

endmodule

// File: tb/sector_bitfix_tb.sv
module sector_bitfix_tb;

  localparam int NB   = 512;
  localparam int NE   = 26;
  localparam int EB   = 13;
  localparam int ML   = 8;
  localparam int LW   = 13;
  localparam int AW   = 9;
  localparam int CW   = 4;
  localparam int ECCB = 4 * NE;
  localparam int CWB  = ECCB + 8 * NB;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [CW-1:0]     err_count = '0;
  logic [ML*LW-1:0]  err_locs = '0;
  logic              uncorrectable = 1'b0;
  logic [EB*8-1:0]   stored_ecc = '0;
  logic [AW-1:0]     buf_addr;
  logic              buf_rd_en;
  logic [7:0]        buf_rdata;
  logic              buf_wr_en;
  logic [7:0]        buf_wdata;
  logic              done;
  logic [1:0]        status;
  logic [CW-1:0]     flips;

  sector_bitfix u_dut (
    .clk (clk), .rst_n (rst_n), .start (start), .err_count (err_count),
    .err_locs (err_locs), .uncorrectable (uncorrectable), .stored_ecc (stored_ecc),
    .buf_addr (buf_addr), .buf_rd_en (buf_rd_en), .buf_rdata (buf_rdata),
    .buf_wr_en (buf_wr_en), .buf_wdata (buf_wdata), .done (done),
    .status (status), .flips (flips)
  );

  logic [7:0] mem  [NB];
  logic [7:0] expm [NB];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem[i] <= 8'(i * 37 + 5);
      buf_rdata <= '0;
    end else begin
      if (buf_rd_en) buf_rdata <= mem[buf_addr];
      if (buf_wr_en) mem[buf_addr] <= buf_wdata;
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  int tl [ML];

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  // protocol monitor (R6)
  logic         prev_rd = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rst_n && buf_wr_en) begin
      check(prev_rd && (prev_addr == buf_addr), "R6 write follows read",
            int'(prev_rd), 1);
      check($countones(buf_wdata ^ mem[buf_addr]) == 1, "R6 one bit inverted",
            $countones(buf_wdata ^ mem[buf_addr]), 1);
    end
    prev_rd   <= buf_rd_en;
    prev_addr <= buf_addr;
  end

  function automatic logic loc_hits(input int l);
    return (l >= ECCB) && (l < CWB);
  endfunction

  // position counted from the front of the data area
  function automatic int loc_byte(input int l);
    return ((CWB - 1) - l) / 8;
  endfunction

  function automatic int loc_bit(input int l);
    return 7 - (((CWB - 1) - l) % 8);
  endfunction

  task automatic compare_mem(input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < NB; i++)
      if (mem[i] !== expm[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    check(bad == 0, req, bad, 0);
    if (bad != 0)
      $display("  first differing byte %0d: actual %0d expected %0d",
               first, mem[first], expm[first]);
  endtask

  // one sector run; returns nothing, checks status/flips/pulse
  task automatic run_case(input int n, input logic unc, input logic era,
                          input logic poke, input string tag);
    int eff, ef;
    int es;
    logic seen;
    eff = (n > ML) ? ML : n;
    ef  = 0;
    if (era) es = 1;
    else if (unc) es = 3;
    else begin
      for (int i = 0; i < eff; i++)
        if (loc_hits(tl[i])) begin
          expm[loc_byte(tl[i])] ^= 8'(1 << loc_bit(tl[i]));
          ef++;
        end
      es = (ef != 0) ? 2 : 0;
    end
    for (int i = 0; i < ML; i++) err_locs[i*LW +: LW] = LW'(tl[i]);
    err_count     = CW'(n);
    uncorrectable = unc;
    stored_ecc    = {(EB*8){1'b1}};
    if (!era) stored_ecc[$urandom_range(0, EB-1)*8 +: 8] = 8'($urandom_range(0, 254));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke && !era && !unc) begin
      @(negedge clk);
      err_count     = CW'($urandom_range(0, 15));
      err_locs      = {ML{13'd700}};
      uncorrectable = 1'b1;
      stored_ecc    = {(EB*8){1'b1}};
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    seen = 1'b0;
    for (int k = 0; k < 100 && !seen; k++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
    check(seen, {tag, " R9 done seen"}, int'(seen), 1);
    check(status == 2'(es), {tag, " status"}, int'(status), es);
    check(int'(flips) == ef, {tag, " R8 flips"}, int'(flips), ef);
    @(negedge clk);
    check(!done && status == 2'(es) && int'(flips) == ef,
          {tag, " R9 pulse and hold"}, int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NB; i++) expm[i] = 8'(i * 37 + 5);
    @(negedge clk);
    // R1
    check(!done && status == 2'b00 && flips == '0 && !buf_rd_en && !buf_wr_en,
          "R1 reset state", int'(status), 0);

    // R4 R5 R7: sweep every location; later slots hold applicable values
    for (int l = 0; l < CWB + 100; l++) begin
      tl[0] = l;
      for (int i = 1; i < ML; i++) tl[i] = 500 + i * 300;
      run_case(1, 1'b0, 1'b0, 1'b0, loc_hits(l) ? "R5 sweep" : "R4 sweep");
      if (loc_hits(l))
        check(mem[loc_byte(l)] == expm[loc_byte(l)], "R5 target byte",
              int'(mem[loc_byte(l)]), int'(expm[loc_byte(l)]));
      if ((l % 512) == 511) compare_mem("R4 R5 memory after sweep block");
    end
    compare_mem("R4 R5 memory after sweep");

    // R5 boundary: first and last data bits
    for (int i = 0; i < ML; i++) tl[i] = 0;
    tl[0] = ECCB; tl[1] = CWB - 1; tl[2] = ECCB - 1; tl[3] = CWB;
    run_case(4, 1'b0, 1'b0, 1'b0, "R5 edges");
    check(loc_byte(ECCB) == NB - 1 && loc_bit(ECCB) == 0, "R5 model first",
          loc_byte(ECCB), NB - 1);
    check(loc_byte(CWB-1) == 0 && loc_bit(CWB-1) == 7, "R5 model last",
          loc_byte(CWB-1), 0);
    compare_mem("R4 R5 edges memory");

    // R7: count above eight clamps
    for (int i = 0; i < ML; i++) tl[i] = 200 + i * 450;
    run_case(12, 1'b0, 1'b0, 1'b0, "R7 clamp");
    compare_mem("R7 clamp memory");
    run_case(15, 1'b0, 1'b0, 1'b0, "R7 clamp max");
    compare_mem("R7 clamp max memory");

    // R8: duplicate restores, count 0 is clean
    tl[0] = 1234; tl[1] = 1234;
    run_case(2, 1'b0, 1'b0, 1'b0, "R8 duplicate");
    compare_mem("R8 duplicate memory");
    run_case(0, 1'b0, 1'b0, 1'b0, "R8 empty");
    compare_mem("R8 empty memory");

    // R3: uncorrectable leaves buffer alone
    for (int i = 0; i < ML; i++) tl[i] = 300 + i * 111;
    run_case(8, 1'b1, 1'b0, 1'b0, "R3 uncorrectable");
    compare_mem("R3 memory untouched");

    // R2: erased wins even over uncorrectable
    run_case(8, 1'b1, 1'b1, 1'b0, "R2 erased+unc");
    run_case(8, 1'b0, 1'b1, 1'b0, "R2 erased");
    compare_mem("R2 memory untouched");

    // R9: start and input changes during a run are ignored
    run_case(8, 1'b0, 1'b0, 1'b1, "R9 busy start");
    compare_mem("R9 busy memory");

    // mixed random runs
    for (int r = 0; r < 300; r++) begin
      for (int i = 0; i < ML; i++) tl[i] = $urandom_range(0, CWB + 200);
      run_case($urandom_range(0, 15), $urandom_range(0, 5) == 0,
               $urandom_range(0, 7) == 0, $urandom_range(0, 3) == 0, "R8 random");
      compare_mem("R5 R7 random memory");
    end

    finish_run();
  end

endmodule